// File: doc/BRIEF.md
# Serial Command Front End for a Quad Digital Potentiometer

This block is the serial slave interface of a four-channel digital potentiometer controller. It takes the four serial pins (clock, data in, select, pause) as asynchronous inputs, brings them into the system clock domain, and finds the serial clock edges there. Each frame opens when select goes low. The first byte carries a device identity and a two-bit board address. The second byte names the command, the register and the potentiometer.

Decoded commands leave the block as one-cycle request strobes to a register bank. Each strobe carries an operation code, a pot index, a register index and, for writes, six data bits. Transfer commands finish after two bytes. Writes, reads and the status read carry a third byte. The step command opens a stream in which every serial clock pulse moves a wiper one tap. For reads the bank returns a six-bit value, and the block shifts it out on the serial output. That output is enabled only while read data is owed. The pause input can freeze a frame part way through without losing its position.

The SCK high and low phases must each last at least 8 system clock cycles. The bank must present `rd_data` within `RD_LAT` cycles after a read strobe.

Top module: `potctl_spi_frontend`

## Requirements
- R1: A frame is acted on only if its first byte equals binary 0101, then 00, then the two `dev_addr` bits (MSB first). Otherwise the whole frame produces no strobe, and `spi_so_oe` stays 0.
- R2: Serial input bits are taken on the rising SCK edge, MSB first. Serial output bits change after the falling SCK edge, MSB first.
- R3: In the second byte, bits 7..4 are the opcode, bits 3..2 are the register index and bits 1..0 are the pot index. These values appear on `req_reg` and `req_pot`.
- R4: Four transfer opcodes each give exactly one strobe once the second byte is complete, with no third byte:
  - 1101 gives `req_op`=5 (data register to wiper).
  - 1110 gives `req_op`=6 (wiper to data register).
  - 0001 gives `req_op`=7 (all pots, data register to wiper).
  - 1000 gives `req_op`=8 (all pots, wiper to data register).
  - Strobes for 7 and 8 report pot 0.
- R5: Opcode 1010 (write wiper, `req_op`=2) and opcode 1100 (write data register, `req_op`=4) take a third byte. The strobe is issued only after select rises. It carries bits 5..0 of that byte on `req_wdata`. No strobe is issued before select rises.
- R6: Opcode 1001 (read wiper, `req_op`=1, register 0) and opcode 1011 (read data register, `req_op`=3) strobe after the second byte. The third byte is then driven out as 00 followed by `rd_data`.
- R7: Second byte 0101 0001 strobes `req_op`=11. The third byte returned is seven zeros followed by `wip`.
- R8: After opcode 0010, every rising SCK edge until select rises gives one strobe for the addressed pot. The strobe is `req_op`=9 (up) if SI is 1, or `req_op`=10 (down) if SI is 0.
- R9: Pause and resume work as follows:
  - Pause starts when HOLD goes low while SCK is low.
  - While paused, SCK edges are ignored and `spi_so_oe` is 0.
  - The frame resumes where it stopped when HOLD goes high while SCK is low.
- R10: After reset, nothing is acted on until select has been seen to fall.
- R11: Select rising clears the frame. A SCK edge arriving in the same cycle as the select rise is discarded. A write whose third byte is incomplete gives no strobe, and the next frame decodes normally.
- R12: Unknown opcodes, and opcode 0101 with a low nibble other than 0001, give no strobe and keep `spi_so_oe` at 0.
- R13: `spi_so_oe` is 1 only in read and status frames after the second byte, and it falls once select is high.
- R14: Every strobe lasts exactly one cycle and appears only after an open frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, asynchronous |
| spi_si | input | 1 | Serial data in |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_hold_n | input | 1 | Pause request, active low |
| dev_addr | input | 2 | Board address strap |
| rd_data | input | DATA_W | Read value from the register bank |
| wip | input | 1 | Write-in-progress flag from the bank |
| req_stb | output | 1 | One-cycle request strobe |
| req_op | output | 4 | Operation code of the request |
| req_pot | output | 2 | Pot index |
| req_reg | output | 2 | Register index |
| req_wdata | output | DATA_W | Write data |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Output enable for the serial output |

## Verification
The risky collision is the select rise landing in the same system cycle as the SCK rise that would complete a write's data byte. Both pins pass through equal synchroniser depth, so the bench raises them on the same clock. The frame end must win, so no write strobe may appear, and a following transfer frame must still decode. A second collision is pause against a clock edge. Bench pulses on SCK while HOLD is low must give neither a step strobe nor a shift of the read byte, and the read data received after resume must be complete and in order.

// File: rtl/potctl_spi_pkg.sv
`timescale 1ns/1ps
package potctl_spi_pkg;

  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;

  // identity prefix: 4-bit device type followed by two zero bits
  localparam logic [5:0] ID_PREFIX = 6'b0101_00;

  // opcode values carried in the upper nibble of the second byte
  localparam logic [3:0] OPC_RD_WIPER   = 4'b1001;
  localparam logic [3:0] OPC_WR_WIPER   = 4'b1010;
  localparam logic [3:0] OPC_RD_DATA    = 4'b1011;
  localparam logic [3:0] OPC_WR_DATA    = 4'b1100;
  localparam logic [3:0] OPC_D2W        = 4'b1101;
  localparam logic [3:0] OPC_W2D        = 4'b1110;
  localparam logic [3:0] OPC_ALL_D2W    = 4'b0001;
  localparam logic [3:0] OPC_ALL_W2D    = 4'b1000;
  localparam logic [3:0] OPC_STEP       = 4'b0010;
  localparam logic [3:0] OPC_STATUS     = 4'b0101;
  localparam logic [3:0] STATUS_LOW     = 4'b0001;

  typedef enum logic [3:0] {
    OP_NONE          = 4'd0,
    OP_RD_WIPER      = 4'd1,
    OP_WR_WIPER      = 4'd2,
    OP_RD_DATA       = 4'd3,
    OP_WR_DATA       = 4'd4,
    OP_DATA_TO_WIPER = 4'd5,
    OP_WIPER_TO_DATA = 4'd6,
    OP_ALL_D2W       = 4'd7,
    OP_ALL_W2D       = 4'd8,
    OP_STEP_UP       = 4'd9,
    OP_STEP_DOWN     = 4'd10,
    OP_RD_STATUS     = 4'd11
  } req_op_e;

  typedef enum logic [3:0] {
    FS_IDLE,
    FS_ID,
    FS_INSTR,
    FS_WDATA,
    FS_WREADY,
    FS_RDATA,
    FS_STEP,
    FS_DONE,
    FS_DROP
  } fstate_e;

endpackage

// File: rtl/potctl_spi_sync.sv
`timescale 1ns/1ps
module potctl_spi_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      for (int s = STAGES - 1; s > 0; s--) pipe[s] <= pipe[s-1];
      pipe[0] <= d;
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/potctl_spi_link.sv
`timescale 1ns/1ps
module potctl_spi_link (
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  input  logic cs_n_s,
  input  logic hold_n_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic frame_start,
  output logic frame_end,
  output logic active,
  output logic paused
);

  logic sck_q;
  logic cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b0;  // select low at reset release is not a falling edge
      active <= 1'b0;
      paused <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
      if (frame_start)  active <= 1'b1;
      else if (cs_n_s)  active <= 1'b0;

      if (!active || cs_n_s)                      paused <= 1'b0;
      else if (!paused && !hold_n_s && !sck_s)    paused <= 1'b1;
      else if (paused && hold_n_s && !sck_s)      paused <= 1'b0;
    end
  end

  logic open_gate;
  assign open_gate   = active & ~cs_n_s & ~paused;
  assign frame_start = cs_q & ~cs_n_s;
  assign frame_end   = active & cs_n_s;
  assign sck_rise    = open_gate & sck_s & ~sck_q;
  assign sck_fall    = open_gate & ~sck_s & sck_q;

  // R11: a frame end leaves the link closed on the next cycle
  p_end_closes_r11: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !active);

  // R9: a pause may only begin while the serial clock is low
  p_pause_entry_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(paused) |-> ($past(sck_s) == 1'b0 && $past(hold_n_s) == 1'b0));

endmodule

// File: rtl/potctl_spi_tx.sv
`timescale 1ns/1ps
module potctl_spi_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         so_bit
);

  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      so_bit <= 1'b0;
    end else if (load) begin
      sr     <= load_val;
      so_bit <= 1'b0;
    end else if (shift) begin
      so_bit <= sr[W-1];
      sr     <= {sr[W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/potctl_spi_frontend.sv
`timescale 1ns/1ps
module potctl_spi_frontend
  import potctl_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 6,
  parameter int RD_LAT      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_si,
  input  logic              spi_cs_n,
  input  logic              spi_hold_n,
  input  logic [1:0]        dev_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wip,
  output logic              req_stb,
  output logic [3:0]        req_op,
  output logic [1:0]        req_pot,
  output logic [1:0]        req_reg,
  output logic [DATA_W-1:0] req_wdata,
  output logic              spi_so,
  output logic              spi_so_oe
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam int PAD_W = BYTE_W - DATA_W;

  // ---------------- pin synchronisation ----------------
  logic [3:0] pins_s;
  logic sck_s, si_s, cs_n_s, hold_n_s;

  potctl_spi_sync #(.STAGES(SYNC_STAGES), .WIDTH(4), .RST_VAL(4'b0001)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sck, spi_si, spi_cs_n, spi_hold_n}),
    .q   (pins_s)
  );
  assign {sck_s, si_s, cs_n_s, hold_n_s} = pins_s;

  // ---------------- edge and frame tracking ----------------
  logic sck_rise, sck_fall, frame_start, frame_end, active, paused;

  potctl_spi_link u_link (
    .clk         (clk),
    .rst         (rst),
    .sck_s       (sck_s),
    .cs_n_s      (cs_n_s),
    .hold_n_s    (hold_n_s),
    .sck_rise    (sck_rise),
    .sck_fall    (sck_fall),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .active      (active),
    .paused      (paused)
  );

  // ---------------- frame state ----------------
  fstate_e             fs;
  logic [CNT_W-1:0]    cnt;
  logic [BYTE_W-2:0]   rx;
  req_op_e             req_op_q;
  req_op_e             wr_op_q;
  logic [SEL_W-1:0]    pot_q, reg_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                drive_q;
  logic                status_q;
  logic                rd_go;

  logic [BYTE_W-1:0]   byte_in;
  logic                byte_done;
  logic [3:0]          opc;
  logic [SEL_W-1:0]    rsel, psel;

  assign byte_in   = {rx, si_s};
  assign byte_done = (cnt == CNT_W'(BYTE_W - 1));
  assign opc       = byte_in[7:4];
  assign rsel      = byte_in[3:2];
  assign psel      = byte_in[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      fs        <= FS_IDLE;
      cnt       <= '0;
      rx        <= '0;
      req_stb   <= 1'b0;
      req_op_q  <= OP_NONE;
      req_pot   <= '0;
      req_reg   <= '0;
      req_wdata <= '0;
      wr_op_q   <= OP_NONE;
      pot_q     <= '0;
      reg_q     <= '0;
      wdata_q   <= '0;
      drive_q   <= 1'b0;
      status_q  <= 1'b0;
      rd_go     <= 1'b0;
    end else begin
      req_stb <= 1'b0;
      rd_go   <= 1'b0;
      if (frame_start) begin
        fs      <= FS_ID;
        cnt     <= '0;
        drive_q <= 1'b0;
      end else if (frame_end) begin
        if (fs == FS_WREADY) begin
          req_stb   <= 1'b1;
          req_op_q  <= wr_op_q;
          req_pot   <= pot_q;
          req_reg   <= reg_q;
          req_wdata <= wdata_q;
        end
        fs      <= FS_IDLE;
        cnt     <= '0;
        drive_q <= 1'b0;
      end else if (sck_rise) begin
        cnt <= cnt + CNT_W'(1);
        rx  <= byte_in[BYTE_W-2:0];
        case (fs)
          FS_ID: if (byte_done) begin
            if (byte_in == {ID_PREFIX, dev_addr}) fs <= FS_INSTR;
            else                                  fs <= FS_DROP;
          end
          FS_INSTR: if (byte_done) begin
            pot_q     <= psel;
            reg_q     <= rsel;
            req_wdata <= '0;
            case (opc)
              OPC_RD_WIPER: begin
                req_stb <= 1'b1; req_op_q <= OP_RD_WIPER;
                req_pot <= psel; req_reg <= '0;
                rd_go <= 1'b1; drive_q <= 1'b1; status_q <= 1'b0;
                fs <= FS_RDATA;
              end
              OPC_RD_DATA: begin
                req_stb <= 1'b1; req_op_q <= OP_RD_DATA;
                req_pot <= psel; req_reg <= rsel;
                rd_go <= 1'b1; drive_q <= 1'b1; status_q <= 1'b0;
                fs <= FS_RDATA;
              end
              OPC_WR_WIPER: begin
                wr_op_q <= OP_WR_WIPER; reg_q <= '0; fs <= FS_WDATA;
              end
              OPC_WR_DATA: begin
                wr_op_q <= OP_WR_DATA; fs <= FS_WDATA;
              end
              OPC_D2W: begin
                req_stb <= 1'b1; req_op_q <= OP_DATA_TO_WIPER;
                req_pot <= psel; req_reg <= rsel; fs <= FS_DONE;
              end
              OPC_W2D: begin
                req_stb <= 1'b1; req_op_q <= OP_WIPER_TO_DATA;
                req_pot <= psel; req_reg <= rsel; fs <= FS_DONE;
              end
              OPC_ALL_D2W: begin
                req_stb <= 1'b1; req_op_q <= OP_ALL_D2W;
                req_pot <= '0; req_reg <= rsel; fs <= FS_DONE;
              end
              OPC_ALL_W2D: begin
                req_stb <= 1'b1; req_op_q <= OP_ALL_W2D;
                req_pot <= '0; req_reg <= rsel; fs <= FS_DONE;
              end
              OPC_STEP: fs <= FS_STEP;
              OPC_STATUS: begin
                if (byte_in[3:0] == STATUS_LOW) begin
                  req_stb <= 1'b1; req_op_q <= OP_RD_STATUS;
                  req_pot <= '0; req_reg <= '0;
                  rd_go <= 1'b1; drive_q <= 1'b1; status_q <= 1'b1;
                  fs <= FS_RDATA;
                end else begin
                  fs <= FS_DROP;
                end
              end
              default: fs <= FS_DROP;
            endcase
          end
          FS_WDATA: if (byte_done) begin
            wdata_q <= byte_in[DATA_W-1:0];
            fs      <= FS_WREADY;
          end
          FS_RDATA: if (byte_done) fs <= FS_DONE;
          FS_STEP: begin
            req_stb   <= 1'b1;
            req_pot   <= pot_q;
            req_reg   <= '0;
            req_wdata <= '0;
            if (si_s) req_op_q <= OP_STEP_UP;
            else      req_op_q <= OP_STEP_DOWN;
          end
          default: ;
        endcase
      end
    end
  end

  assign req_op = req_op_q;

  // ---------------- read return path ----------------
  logic [RD_LAT-1:0] rd_dly;
  logic              tx_load;

  always_ff @(posedge clk) begin
    if (rst || frame_end) rd_dly <= '0;
    else                  rd_dly <= (rd_dly << 1) | RD_LAT'(rd_go);
  end
  assign tx_load = rd_dly[RD_LAT-1];

  logic [BYTE_W-1:0] tx_val;
  logic              so_bit;

  assign tx_val = status_q ? {{(BYTE_W-1){1'b0}}, wip}
                           : {{PAD_W{1'b0}}, rd_data};

  potctl_spi_tx #(.W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .load     (tx_load),
    .load_val (tx_val),
    .shift    (sck_fall & drive_q),
    .so_bit   (so_bit)
  );

  assign spi_so_oe = drive_q & ~paused;
  assign spi_so    = spi_so_oe & so_bit;

  // ---------------- assertions ----------------
  // R1 and R12: a dropped frame stays silent
  p_drop_silent_r1: assert property (@(posedge clk) disable iff (rst)
    (fs == FS_DROP && $past(fs) == FS_DROP) |-> (!req_stb && !spi_so_oe));

  // R13: with select high for two cycles the output is released
  p_idle_release_r13: assert property (@(posedge clk) disable iff (rst)
    (cs_n_s && $past(cs_n_s)) |-> !spi_so_oe);

  // R14: strobes are single-cycle
  p_stb_pulse_r14: assert property (@(posedge clk) disable iff (rst)
    req_stb |=> !req_stb);

  // R10: a strobe only follows an open frame
  p_stb_in_frame_r10: assert property (@(posedge clk) disable iff (rst)
    req_stb |-> $past(active));

  // R5: write strobes follow the select rise
  p_write_at_end_r5: assert property (@(posedge clk) disable iff (rst)
    (req_stb && (req_op_q == OP_WR_WIPER || req_op_q == OP_WR_DATA)) |-> $past(cs_n_s));

  // R8: an upward step follows a high data bit
  p_step_dir_r8: assert property (@(posedge clk) disable iff (rst)
    (req_stb && req_op_q == OP_STEP_UP) |-> $past(si_s));

endmodule

// File: tb/sim_potctl_spi_frontend.sv
`timescale 1ns/1ps
module sim_potctl_spi_frontend;

  localparam int HALF = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       sck = 1'b0, si = 1'b0, cs_n = 1'b0, hold_n = 1'b1;
  logic [1:0] dev_addr = 2'b10;
  logic [5:0] rd_data = '0;
  logic       wip = 1'b0;
  logic       req_stb;
  logic [3:0] req_op;
  logic [1:0] req_pot, req_reg;
  logic [5:0] req_wdata;
  logic       so, so_oe;

  potctl_spi_frontend u0 (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_si(si), .spi_cs_n(cs_n),
    .spi_hold_n(hold_n), .dev_addr(dev_addr), .rd_data(rd_data), .wip(wip),
    .req_stb(req_stb), .req_op(req_op), .req_pot(req_pot), .req_reg(req_reg),
    .req_wdata(req_wdata), .spi_so(so), .spi_so_oe(so_oe)
  );

  // register bank model: returns {pot, reg, 2'b11}
  always @(posedge clk) if (req_stb) rd_data <= {req_pot, req_reg, 2'b11};

  int         n_stb = 0;
  bit         oe_seen = 1'b0;
  logic [3:0] lg_op [16];
  logic [1:0] lg_pot [16];
  logic [1:0] lg_reg [16];
  logic [5:0] lg_dat [16];

  always @(negedge clk) begin
    if (req_stb && n_stb < 16) begin
      lg_op[n_stb] = req_op; lg_pot[n_stb] = req_pot;
      lg_reg[n_stb] = req_reg; lg_dat[n_stb] = req_wdata;
      n_stb = n_stb + 1;
    end
    if (so_oe) oe_seen = 1'b1;
  end

  int n_checks = 0, n_fail = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    n_stb = 0; oe_seen = 1'b0;
  endtask

  task automatic cs_low();
    cs_n = 1'b0; tick(HALF);
  endtask

  task automatic cs_high();
    tick(HALF); cs_n = 1'b1; tick(3 * HALF);
  endtask

  task automatic pulse_bit(input logic b);
    si = b; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i]; tick(HALF); rx[i] = so; sck = 1'b1; tick(HALF); sck = 1'b0;
    end
  endtask

  function automatic logic [7:0] id_byte(input logic [1:0] a);
    return {6'b010100, a};
  endfunction

  task automatic two_byte(input logic [7:0] b0, input logic [7:0] b1);
    logic [7:0] r;
    cs_low(); xfer(b0, r); xfer(b1, r); cs_high();
  endtask

  task automatic expect_one(input string tag, input int op, input int pot, input int rg);
    check({tag, " strobe count"}, n_stb, 1);
    if (n_stb >= 1) begin
      check({tag, " op"}, lg_op[0], op);
      check({tag, " pot"}, lg_pot[0], pot);
      check({tag, " reg"}, lg_reg[0], rg);
    end
  endtask

  // R10: no frame before a select falling edge
  task automatic t_no_fall();
    logic [7:0] r;
    clear_log();
    xfer(id_byte(dev_addr), r); xfer(8'hDB, r);
    cs_high();
    check("R10 no strobe without select fall", n_stb, 0);
  endtask

  // R3 R4: transfer commands
  task automatic t_transfer();
    clear_log(); two_byte(id_byte(dev_addr), 8'hDB);
    expect_one("R4 R3 data-to-wiper", 5, 3, 2);
    clear_log(); two_byte(id_byte(dev_addr), 8'hE4);
    expect_one("R4 wiper-to-data", 6, 0, 1);
    clear_log(); two_byte(id_byte(dev_addr), 8'h1C);
    expect_one("R4 all data-to-wiper", 7, 0, 3);
    clear_log(); two_byte(id_byte(dev_addr), 8'h8B);
    expect_one("R4 all wiper-to-data", 8, 0, 2);
  endtask

  // R1: identity mismatches
  task automatic t_badid();
    clear_log(); two_byte(id_byte(2'b01), 8'hDB);
    check("R1 wrong address strobes", n_stb, 0);
    clear_log(); two_byte(8'h5E, 8'hDB);
    check("R1 nonzero middle bits strobes", n_stb, 0);
    clear_log(); two_byte(8'h72, 8'h96);
    check("R1 wrong prefix strobes", n_stb, 0);
    check("R1 output enable seen", oe_seen, 0);
  endtask

  // R5: writes issue at select rise
  task automatic t_write();
    logic [7:0] r;
    clear_log();
    cs_low(); xfer(id_byte(dev_addr), r); xfer(8'hA1, r); xfer(8'h2A, r);
    tick(HALF);
    check("R5 no strobe before select rise", n_stb, 0);
    cs_high();
    expect_one("R5 write wiper", 2, 1, 0);
    if (n_stb >= 1) check("R5 write wiper data", lg_dat[0], 42);
    clear_log();
    cs_low(); xfer(id_byte(dev_addr), r); xfer(8'hCE, r); xfer(8'hFF, r); cs_high();
    expect_one("R5 write data register", 4, 2, 3);
    if (n_stb >= 1) check("R5 write data low six bits", lg_dat[0], 63);
    check("R13 no output enable in write frames", oe_seen, 0);
  endtask

  // R11: short write, then normal frame
  task automatic t_short();
    logic [7:0] r;
    clear_log();
    cs_low(); xfer(id_byte(dev_addr), r); xfer(8'hA1, r);
    for (int i = 0; i < 5; i++) pulse_bit(1'b1);
    cs_high();
    check("R11 short write strobes", n_stb, 0);
    clear_log();
    cs_low(); xfer(id_byte(dev_addr), r); xfer(8'hA2, r); xfer(8'h15, r); cs_high();
    expect_one("R11 frame after short write", 2, 2, 0);
    if (n_stb >= 1) check("R11 data after short write", lg_dat[0], 21);
  endtask

  // R11: last clock edge coincides with select rise
  task automatic t_coincident();
    logic [7:0] r;
    clear_log();
    cs_low(); xfer(id_byte(dev_addr), r); xfer(8'hA1, r);
    for (int i = 7; i >= 1; i--) pulse_bit(i[0]);
    si = 1'b0; tick(HALF); sck = 1'b1; cs_n = 1'b1; tick(HALF); sck = 1'b0;
    tick(3 * HALF);
    check("R11 coincident edge write strobes", n_stb, 0);
    clear_log(); two_byte(id_byte(dev_addr), 8'hD5);
    expect_one("R11 transfer after coincident end", 5, 1, 1);
  endtask

  // R6 R2 R13: reads
  task automatic t_read();
    logic [7:0] r;
    clear_log();
    cs_low(); xfer(id_byte(dev_addr), r);
    check("R13 output off before command", so_oe, 0);
    xfer(8'hB6, r); xfer(8'h00, r);
    check("R6 R2 read data register byte", r, 8'h27);
    check("R13 output on during read", oe_seen, 1);
    cs_high();
    check("R13 output off after select rise", so_oe, 0);
    expect_one("R6 read data register", 3, 2, 1);
    clear_log();
    cs_low(); xfer(id_byte(dev_addr), r); xfer(8'h93, r); xfer(8'h00, r); cs_high();
    check("R6 R2 read wiper byte", r, 8'h33);
    expect_one("R6 read wiper", 1, 3, 0);
  endtask

  // R7: status
  task automatic t_status();
    logic [7:0] r;
    wip = 1'b1; clear_log();
    cs_low(); xfer(id_byte(dev_addr), r); xfer(8'h51, r); xfer(8'h00, r); cs_high();
    check("R7 status with write busy", r, 8'h01);
    expect_one("R7 status strobe", 11, 0, 0);
    wip = 1'b0;
    cs_low(); xfer(id_byte(dev_addr), r); xfer(8'h51, r); xfer(8'h00, r); cs_high();
    check("R7 status idle", r, 8'h00);
  endtask

  // R12: unknown codes
  task automatic t_unknown();
    logic [7:0] r;
    clear_log();
    cs_low(); xfer(id_byte(dev_addr), r); xfer(8'h3F, r); xfer(8'hFF, r); cs_high();
    cs_low(); xfer(id_byte(dev_addr), r); xfer(8'h5F, r); xfer(8'hFF, r); cs_high();
    check("R12 unknown opcode strobes", n_stb, 0);
    check("R12 unknown opcode output enable", oe_seen, 0);
  endtask

  // R8: step stream
  task automatic t_step();
    logic [7:0] r;
    clear_log();
    cs_low(); xfer(id_byte(dev_addr), r); xfer(8'h21, r);
    pulse_bit(1'b1); pulse_bit(1'b1); pulse_bit(1'b0);
    cs_high();
    check("R8 step count", n_stb, 3);
    if (n_stb == 3) begin
      check("R8 step 1 up", lg_op[0], 9);
      check("R8 step 2 up", lg_op[1], 9);
      check("R8 step 3 down", lg_op[2], 10);
      check("R8 step pot", lg_pot[2], 1);
    end
  endtask

  task automatic pause_with_pulses();
    hold_n = 1'b0; tick(HALF);
    check("R9 output off while paused", so_oe, 0);
    pulse_bit(1'b1); pulse_bit(1'b0);
    hold_n = 1'b1; tick(HALF);
  endtask

  // R9: pause and resume
  task automatic t_hold();
    logic [7:0] r;
    clear_log();
    cs_low(); xfer(id_byte(dev_addr), r); xfer(8'hB6, r);
    for (int i = 7; i >= 0; i--) begin
      if (i == 4) pause_with_pulses();
      si = 1'b0; tick(HALF); r[i] = so; sck = 1'b1; tick(HALF); sck = 1'b0;
    end
    cs_high();
    check("R9 read byte across pause", r, 8'h27);
    clear_log();
    cs_low(); xfer(id_byte(dev_addr), r); xfer(8'h21, r);
    pulse_bit(1'b1);
    pause_with_pulses();
    pulse_bit(1'b0);
    cs_high();
    check("R9 steps across pause", n_stb, 2);
    if (n_stb == 2) begin
      check("R9 step before pause", lg_op[0], 9);
      check("R9 step after pause", lg_op[1], 10);
    end
  endtask

  bit finished = 1'b0;

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    check("R10 reset strobe", req_stb, 0);
    check("R13 reset output enable", so_oe, 0);
    check("R13 reset output value", so, 0);
    t_no_fall();
    t_transfer();
    t_badid();
    t_write();
    t_short();
    t_coincident();
    t_read();
    t_status();
    t_unknown();
    t_step();
    t_hold();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule